// File: doc/BRIEF.md
# Conditional Microoperation Register Unit

This block is a small register-transfer datapath. It holds a parameterised number of n-bit registers. On each rising clock edge it may apply one microoperation to one destination register. The microoperation reads one or two source registers. It can be a load from an external data input, a copy, arithmetic, bitwise logic, or a zero-filling shift.

A transfer takes place only when its control expression is true. The control expression is the OR of the control variables that a mask selects. When it is false, every register keeps its value. The hold comes from feeding each register's output back through a 2-to-1 multiplexer. The clock is never gated.

A single mode bit turns the add operation into a subtract. With the bit set, the add uses the two's complement of the second source. A carry flag records the carry-out of the last arithmetic transfer that took place. The contents of all registers are visible at the outputs all the time. Initial values are placed in the registers with the load operation.

Top module: `microop_reg_unit`

## Requirements
- R1: A synchronous reset (`rst`=1 at a rising edge) clears every register and the carry flag to zero. Reset takes priority over any transfer requested in the same cycle.
- R2: The control expression is `|(ctl_var & ctl_mask)`. When it is 0, no register and not the carry flag changes at that edge, whatever the opcode.
- R3: Opcode 1 with `mode_sub`=0 writes (A + B) mod 2^W to the destination. The carry flag takes the carry-out of that sum.
- R4: Opcode 1 with `mode_sub`=1 writes A + ~B + 1 (that is, A − B mod 2^W) to the destination. The carry flag becomes 1 exactly when A ≥ B.
- R5: Opcode 2 writes A+1 and sets carry = (A == all ones). Opcode 3 writes A−1 and sets carry = (A != 0). Both wrap modulo 2^W.
- R6: Opcode 4 writes ~A. Opcode 5 writes ~A+1, with carry = (A == 0). Opcode 6 writes B + ~A + 1 (B − A), with carry = (B ≥ A). Opcode 4 does not touch the carry flag.
- R7: Opcodes 7, 8 and 9 write A AND B, A OR B and A XOR B, bitwise over the whole word.
- R8: Opcode 10 shifts A left by one bit and opcode 11 shifts A right by one bit. In both cases the vacated bit is filled with 0.
- R9: Opcode 0 writes `load_data` to the destination. Opcode 12 copies A to the destination.
- R10: At most one register changes per edge, and it is the one that `dst_sel` selects. Opcodes 13 to 15 change nothing. A destination may also be one of its own sources, and then the old value is used.
- R11: The carry flag is updated only by a firing opcode from 1 to 6, excluding opcode 4. Every other edge leaves it unchanged.
- R12: The result appears in the destination on the rising edge at which the operation is presented with a true control expression. Register i is shown at `reg_view[i*W +: W]`. A is register `srca_sel` and B is register `srcb_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Microoperation code |
| mode_sub | input | 1 | Makes opcode 1 subtract instead of add |
| ctl_var | input | NCTL | Control variables |
| ctl_mask | input | NCTL | Selects which control variables form the control expression |
| dst_sel | input | $clog2(NREG) | Destination register index |
| srca_sel | input | $clog2(NREG) | First source register index (A) |
| srcb_sel | input | $clog2(NREG) | Second source register index (B) |
| load_data | input | W | External value written by opcode 0 |
| reg_view | output | NREG*W | All register contents, register i at bits i*W upward |
| carry_flag | output | 1 | Carry-out of the last arithmetic transfer |

## Verification
Two functions can coincide in one cycle. The first case is a register being read as a source and written as the destination at the same edge. The bench provokes this by sending add and subtract operations whose destination equals one or both sources. It expects the result to be computed from the value held before the edge. The second case is a reset arriving together with a firing transfer. The bench requests a load with a true control expression while reset is high. It judges the cycle by requiring all registers and the carry flag to read zero afterwards.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

  typedef enum logic [3:0] {
    OP_LOAD   = 4'd0,
    OP_ADDSUB = 4'd1,
    OP_INC    = 4'd2,
    OP_DEC    = 4'd3,
    OP_ONES   = 4'd4,
    OP_TWOS   = 4'd5,
    OP_RSUB   = 4'd6,
    OP_AND    = 4'd7,
    OP_OR     = 4'd8,
    OP_XOR    = 4'd9,
    OP_SHL    = 4'd10,
    OP_SHR    = 4'd11,
    OP_COPY   = 4'd12
  } rtu_op_e;

  // Opcodes 13..15 name no transfer.
  function automatic logic op_known(input logic [3:0] op);
    return op <= 4'd12;
  endfunction

  // Operations whose carry-out is recorded in the flag.
  function automatic logic op_sets_carry(input logic [3:0] op);
    return (op == OP_ADDSUB) || (op == OP_INC) || (op == OP_DEC) ||
           (op == OP_TWOS) || (op == OP_RSUB);
  endfunction

endpackage

// File: rtl/rtu_alu.sv
module rtu_alu #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic         sub_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] ext,
  output logic [W-1:0] res,
  output logic         carry
);
  import rtu_pkg::*;

  localparam logic [W:0] ONE_X  = (W+1)'(1);
  localparam logic [W:0] ONES_X = {1'b0, {W{1'b1}}};

  // Result in the low W bits, carry-out in bit W.
  function automatic logic [W:0] alu_fn(input logic [3:0] f,
                                        input logic m,
                                        input logic [W-1:0] x,
                                        input logic [W-1:0] y,
                                        input logic [W-1:0] e);
    logic [W:0] xe, ye, nxe, nye;
    xe  = {1'b0, x};
    ye  = {1'b0, y};
    nxe = {1'b0, ~x};
    nye = {1'b0, ~y};
    case (f)
      OP_LOAD:   return {1'b0, e};
      OP_ADDSUB: return m ? (xe + nye + ONE_X) : (xe + ye);
      OP_INC:    return xe + ONE_X;
      OP_DEC:    return xe + ONES_X;
      OP_ONES:   return nxe;
      OP_TWOS:   return nxe + ONE_X;
      OP_RSUB:   return ye + nxe + ONE_X;
      OP_AND:    return {1'b0, x & y};
      OP_OR:     return {1'b0, x | y};
      OP_XOR:    return {1'b0, x ^ y};
      OP_SHL:    return {1'b0, x[W-2:0], 1'b0};
      OP_SHR:    return {1'b0, 1'b0, x[W-1:1]};
      OP_COPY:   return {1'b0, x};
      default:   return {1'b0, x};
    endcase
  endfunction

  logic [W:0] full;

  always_comb begin
    full  = alu_fn(op, sub_mode, a, b, ext);
    res   = full[W-1:0];
    carry = full[W];
  end

endmodule

// File: rtl/rtu_ctl.sv
module rtu_ctl #(
  parameter int NREG = 4,
  parameter int NCTL = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3:0]              op,
  input  logic [NCTL-1:0]         var_in,
  input  logic [NCTL-1:0]         mask_in,
  input  logic [$clog2(NREG)-1:0] dst,
  output logic                    fire,
  output logic                    carry_en,
  output logic [NREG-1:0]         we_vec
);
  import rtu_pkg::*;

  localparam int SW = $clog2(NREG);

  logic cond_true;

  always_comb begin
    cond_true = |(var_in & mask_in);
    fire      = cond_true && op_known(op);
    carry_en  = fire && op_sets_carry(op);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign we_vec[i] = fire && (dst == SW'(i));
  end

  assert_we_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_vec));

  assert_no_we_when_false_R2: assert property (@(posedge clk) disable iff (rst)
    !cond_true |-> (we_vec == '0));

endmodule

// File: rtl/rtu_slot.sv
module rtu_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  // Load-controlled feedback: a 2-to-1 mux in front of the flops.
  always_comb nxt = we ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assert_slot_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/microop_reg_unit.sv
module microop_reg_unit #(
  parameter int W    = 8,
  parameter int NREG = 4,
  parameter int NCTL = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3:0]              op_sel,
  input  logic                    mode_sub,
  input  logic [NCTL-1:0]         ctl_var,
  input  logic [NCTL-1:0]         ctl_mask,
  input  logic [$clog2(NREG)-1:0] dst_sel,
  input  logic [$clog2(NREG)-1:0] srca_sel,
  input  logic [$clog2(NREG)-1:0] srcb_sel,
  input  logic [W-1:0]            load_data,
  output logic [NREG*W-1:0]       reg_view,
  output logic                    carry_flag
);

  logic [W-1:0]    reg_q [NREG];
  logic [NREG-1:0] we_vec;
  logic            fire, carry_en;
  logic [W-1:0]    opa, opb, alu_res;
  logic            alu_carry;
  logic            carry_q;

  rtu_ctl #(.NREG(NREG), .NCTL(NCTL)) ctl_i (
    .clk(clk), .rst(rst), .op(op_sel), .var_in(ctl_var), .mask_in(ctl_mask),
    .dst(dst_sel), .fire(fire), .carry_en(carry_en), .we_vec(we_vec)
  );

  always_comb begin
    opa = reg_q[srca_sel];
    opb = reg_q[srcb_sel];
  end

  rtu_alu #(.W(W)) alu_i (
    .op(op_sel), .sub_mode(mode_sub), .a(opa), .b(opb), .ext(load_data),
    .res(alu_res), .carry(alu_carry)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    rtu_slot #(.W(W)) slot_i (
      .clk(clk), .rst(rst), .we(we_vec[i]), .d(alu_res), .q(reg_q[i])
    );
    assign reg_view[i*W +: W] = reg_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)           carry_q <= 1'b0;
    else if (carry_en) carry_q <= alu_carry;
  end

  assign carry_flag = carry_q;

  assert_quiet_when_false_R2: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(reg_view) && $stable(carry_flag)));

  assert_carry_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !carry_en |=> $stable(carry_flag));

  assert_carry_capture_R3: assert property (@(posedge clk) disable iff (rst)
    carry_en |=> (carry_flag == $past(alu_carry)));

  assert_dst_written_R12: assert property (@(posedge clk) disable iff (rst)
    fire |=> (reg_view[$past(dst_sel)*W +: W] == $past(alu_res)));

endmodule

// File: tb/microop_reg_unit_tb_top.sv
module microop_reg_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int BN = 4;
  localparam int BC = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    op_sel;
  logic          mode_sub;
  logic [BC-1:0] ctl_var, ctl_mask;
  logic [1:0]    dst_sel, srca_sel, srcb_sel;
  logic [BW-1:0] load_data;
  logic [BN*BW-1:0] reg_view;
  logic          carry_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int m [BN];
  int mc;

  always #(CLK_PERIOD/2) clk = ~clk;

  microop_reg_unit #(.W(BW), .NREG(BN), .NCTL(BC)) dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .mode_sub(mode_sub),
    .ctl_var(ctl_var), .ctl_mask(ctl_mask), .dst_sel(dst_sel),
    .srca_sel(srca_sel), .srcb_sel(srcb_sel), .load_data(load_data),
    .reg_view(reg_view), .carry_flag(carry_flag)
  );

  function automatic string tag_of(input int op, input int x);
    case (op)
      0, 12:      return "R9";
      1:          return x ? "R4" : "R3";
      2, 3:       return "R5";
      4, 5, 6:    return "R6";
      7, 8, 9:    return "R7";
      10, 11:     return "R8";
      default:    return "R10";
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [BN*BW-1:0] expv;
    for (int i = 0; i < BN; i++) expv[i*BW +: BW] = BW'(m[i]);
    n_checks++;
    if (reg_view !== expv || carry_flag !== 1'(mc)) begin
      n_fail++;
      $display("FAIL %s: regs=%h carry=%b expected regs=%h carry=%0d",
               tag, reg_view, carry_flag, expv, mc);
    end
  endtask

  // Called just after a falling edge; checks at the next falling edge.
  task automatic step(input int op, input int x, input int k, input int mk,
                      input int d, input int sa, input int sb, input int data,
                      input string tag);
    int a, b, r, c;
    bit fire, wr_c;
    logic [BW-1:0] la, lb;
    op_sel = 4'(op); mode_sub = 1'(x); ctl_var = BC'(k); ctl_mask = BC'(mk);
    dst_sel = 2'(d); srca_sel = 2'(sa); srcb_sel = 2'(sb); load_data = BW'(data);
    a = m[sa]; b = m[sb]; la = BW'(a); lb = BW'(b);
    fire = ((k & mk) != 0) && (op <= 12);
    r = a; c = mc; wr_c = 0;
    case (op)
      0:  r = data;
      1:  if (x == 0) begin r = (a + b) % 16; c = (a + b >= 16); wr_c = 1; end
          else        begin r = (a - b + 16) % 16; c = (a >= b); wr_c = 1; end
      2:  begin r = (a + 1) % 16; c = (a == 15); wr_c = 1; end
      3:  begin r = (a + 15) % 16; c = (a != 0); wr_c = 1; end
      4:  r = 15 - a;
      5:  begin r = (16 - a) % 16; c = (a == 0); wr_c = 1; end
      6:  begin r = (b - a + 16) % 16; c = (b >= a); wr_c = 1; end
      7:  r = int'(la & lb);
      8:  r = int'(la | lb);
      9:  r = int'(la ^ lb);
      10: r = (a * 2) % 16;
      11: r = a / 2;
      12: r = a;
      default: r = a;
    endcase
    if (fire) begin
      m[d] = r;
      if (wr_c) mc = c;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; op_sel = 4'd0; mode_sub = 1'b0; ctl_var = '0; ctl_mask = '0;
    dst_sel = '0; srca_sel = '0; srcb_sel = '0; load_data = '0;
    for (int i = 0; i < BN; i++) m[i] = 0;
    mc = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst = 1'b0;

    // Exhaustive sweep over both operands for every transfer opcode (R3..R9).
    for (int av = 0; av < 16; av++) begin
      for (int bv = 0; bv < 16; bv++) begin
        step(0, 0, 1, 1, 1, 0, 0, av, "R9");
        step(0, 0, 2, 3, 2, 0, 0, bv, "R9");
        for (int op = 1; op <= 12; op++)
          step(op, 0, (av % 2) ? 2 : 1, 3, 0, 1, 2, 0, tag_of(op, 0));
        step(1, 1, 1, 1, 3, 1, 2, 0, "R4");
      end
    end

    // Control expression false: nothing moves (R2).
    step(0, 0, 3, 3, 1, 0, 0, 9, "R9");
    step(1, 0, 3, 3, 0, 1, 1, 0, "R3");
    for (int op = 0; op < 16; op++) begin
      step(op, 0, 1, 2, 0, 1, 1, 5, "R2");
      step(op, 1, 0, 3, 2, 1, 2, 7, "R2");
    end

    // Undefined opcodes change nothing even when firing (R10).
    for (int op = 13; op < 16; op++) step(op, 0, 3, 3, 1, 2, 0, 11, "R10");

    // Destination equals source: old value used (R10).
    step(0, 0, 1, 1, 3, 0, 0, 13, "R9");
    step(1, 0, 1, 1, 3, 3, 3, 0, "R10");
    step(1, 1, 1, 1, 3, 3, 3, 0, "R10");
    step(2, 0, 1, 1, 3, 3, 3, 0, "R5");

    // Copy to every destination; only that one changes (R10, R12).
    for (int d = 0; d < BN; d++) begin
      step(0, 0, 1, 1, d, 0, 0, d + 4, "R12");
      step(12, 0, 2, 2, (d + 1) % BN, d, 0, 0, "R10");
    end

    // Logic ops leave the carry alone (R11).
    step(0, 0, 1, 1, 0, 0, 0, 15, "R9");
    step(2, 0, 1, 1, 1, 0, 0, 0, "R11");
    step(7, 0, 1, 1, 2, 0, 0, 0, "R11");
    step(10, 0, 1, 1, 2, 0, 0, 0, "R11");

    // Reset together with a firing load: reset wins (R1).
    op_sel = 4'd0; ctl_var = 2'b01; ctl_mask = 2'b01; dst_sel = 2'd1;
    load_data = 4'hF; rst = 1'b1;
    for (int i = 0; i < BN; i++) m[i] = 0;
    mc = 0;
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    step(0, 0, 1, 1, 2, 0, 0, 6, "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule